// File: doc/BRIEF.md
# Watchdog and Reset Pulse Supervisor

This block supervises a processor by watching a single activity line and producing an active-low reset and a watchdog status flag. A reset cycle can be triggered by supply loss (a power-good input stands in for the supply comparator), by an external pushbutton held long enough and then released, or by the activity line staying quiet longer than the programmed timeout. Every reset cycle holds the reset output low for a fixed pulse width before releasing it.

All time is measured in cycles of a prescaled tick enable, and every duration is a parameter in ticks, so the same logic serves real-time defaults and shortened simulation settings. A 3-bit select from a host register picks the timeout. A disable input models the detection of an unconnected activity line and parks the watchdog. While the activity line stays stuck, reset pulses repeat at a fixed period, and the status output stays low until the line moves again.

Top module: `wdt_reset_supervisor`

## Requirements
- R1: Any level change on `wdi_i` that lasts at least one clock, in either direction, restarts the timeout count from zero; a one-clock pulse gives two changes and also restarts it.
- R2: The timeout in ticks is `DEF_T` for select code 0 and `UNIT_T << (code-1)` for codes 1 to 7; reset is still inactive after timeout-1 ticks without a change and goes active on the timeout-th tick.
- R3: On a watchdog timeout, `rst_no` and `wdo_o` both go low on the same tick, and `rst_no` stays low for exactly `RST_T` ticks.
- R4: After a timeout, `wdo_o` stays low, also after the reset pulse ends, until the next change on `wdi_i`, which sets it high even during a reset pulse.
- R5: While `wdi_i` stays stuck after a timeout, a new reset pulse starts `REPEAT_T` ticks after the start of the previous one.
- R6: While `pwr_good_i` is low, `rst_no` is low within one clock and stays low; after it returns high, `rst_no` releases after exactly `RST_T` ticks.
- R7: `btn_ni` held low for at least `BTN_T` ticks and then released starts a reset pulse of `RST_T` ticks; a hold shorter than `BTN_T` ticks causes no reset.
- R8: A button press made while a reset pulse is active is ignored: no further pulse follows once it is released.
- R9: While `wd_dis_i` is high or `pwr_good_i` is low, no timeout occurs and `wdo_o` is high within one clock, even if it was low before.
- R10: After any reset pulse ends, whether from power, button or watchdog, the timeout count restarts at zero against the currently selected timeout.
- R11: After `rst_ni` deassertion the block is in a reset cycle (`rst_no` low, `wdo_o` high) that ends after `RST_T` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, treated as power-on |
| tick_i | input | 1 | Prescaled time-base enable, one clock wide |
| pwr_good_i | input | 1 | Supply within tolerance |
| wd_dis_i | input | 1 | Watchdog disable (activity line unconnected) |
| wd_sel_i | input | 3 | Timeout select code from host register |
| wdi_i | input | 1 | Watchdog activity line, asynchronous |
| btn_ni | input | 1 | Pushbutton reset request, active low, asynchronous |
| rst_no | output | 1 | Reset output, active low |
| wdo_o | output | 1 | Watchdog status, low after a timeout |

## Verification
A change on `wdi_i` or `btn_ni` needs two synchronizer clocks and one further clock to take effect, so the bench waits four clocks after each such change before issuing any tick. Each tick is a one-clock pulse followed by two idle clocks, and timeouts, pulse ends and releases take effect on the clock edge that consumes the tick, so the bench samples after whole ticks: timeout-1 ticks must leave the output unchanged and the next tick must change it. Power loss and disable act on the next clock, and the bench checks them after two clocks.

// File: rtl/wdt_sup_pkg.sv
package wdt_sup_pkg;

  // Timeout in ticks for a select code: code 0 is the default, others a power-of-two ladder.
  function automatic int unsigned wd_limit(input logic [2:0] code,
                                           input int unsigned def_t,
                                           input int unsigned unit_t);
    if (code == 3'd0) return def_t;
    return unit_t << (int'(code) - 1);
  endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_sup_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DEF_T  = 1500,
  parameter int UNIT_T = 100,
  parameter int GAP_T  = 2800
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       pwr_good_i,
  input  logic       dis_i,
  input  logic       in_rst_i,
  input  logic       wdi_s_i,
  input  logic [2:0] sel_i,
  output logic       wdo_o,
  output logic       timeout_o
);
  logic             prev_q, wdo_q, act, edge_det;
  logic [CNT_W-1:0] elapsed_q, limit;

  assign edge_det = wdi_s_i ^ prev_q;
  assign act      = pwr_good_i && !dis_i && !in_rst_i;
  // stuck mode (status low) uses the repeat gap instead of the programmed timeout
  assign limit    = wdo_q ? CNT_W'(wd_limit(sel_i, DEF_T, UNIT_T)) : CNT_W'(GAP_T);
  assign timeout_o = act && !edge_det && tick_i && (elapsed_q >= limit - CNT_W'(1));
  assign wdo_o    = wdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= 1'b0;
      elapsed_q <= '0;
      wdo_q     <= 1'b1;
    end else begin
      prev_q <= wdi_s_i;
      if (!act || edge_det)  elapsed_q <= '0;
      else if (timeout_o)    elapsed_q <= '0;
      else if (tick_i)       elapsed_q <= elapsed_q + CNT_W'(1);

      if (!pwr_good_i || dis_i) wdo_q <= 1'b1;
      else if (edge_det)        wdo_q <= 1'b1;
      else if (timeout_o)       wdo_q <= 1'b0;
    end
  end

  // R9
  wdo_parked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_good_i || dis_i) |=> wdo_o);
  // R3
  wdo_fall_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdo_q) |-> $past(tick_i));
endmodule

// File: rtl/wdt_btn.sv
module wdt_btn #(
  parameter int CNT_W = 16,
  parameter int BTN_T = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic btn_s_ni,
  input  logic in_rst_i,
  output logic start_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (in_rst_i || btn_s_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (tick_i && !armed_q) begin
      if (cnt_q == CNT_W'(BTN_T - 1)) armed_q <= 1'b1;
      else                            cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  // request fires on release of a long-enough hold
  assign start_o = armed_q && btn_s_ni && !in_rst_i;
endmodule

// File: rtl/wdt_rst_gen.sv
module wdt_rst_gen #(
  parameter int CNT_W = 16,
  parameter int RST_T = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pwr_good_i,
  input  logic start_i,
  output logic in_rst_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             in_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_rst_q <= 1'b1;
      cnt_q    <= '0;
    end else if (!pwr_good_i) begin
      in_rst_q <= 1'b1;
      cnt_q    <= '0;
    end else if (start_i && !in_rst_q) begin
      in_rst_q <= 1'b1;
      cnt_q    <= '0;
    end else if (in_rst_q && tick_i) begin
      if (cnt_q == CNT_W'(RST_T - 1)) begin
        in_rst_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign in_rst_o = in_rst_q;

  // R6
  pwr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> in_rst_q);
  // R3
  release_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_rst_q) |-> $past(tick_i) && $past(pwr_good_i));
endmodule

// File: rtl/wdt_reset_supervisor.sv
module wdt_reset_supervisor #(
  parameter int CNT_W       = 16,
  parameter int DEF_T       = 1500,
  parameter int UNIT_T      = 100,
  parameter int REPEAT_T    = 3000,
  parameter int RST_T       = 200,
  parameter int BTN_T       = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       pwr_good_i,
  input  logic       wd_dis_i,
  input  logic [2:0] wd_sel_i,
  input  logic       wdi_i,
  input  logic       btn_ni,
  output logic       rst_no,
  output logic       wdo_o
);
  localparam int GAP_T = REPEAT_T - RST_T;

  logic wdi_s, btn_s_n, in_rst, wd_timeout, btn_start;

  wdt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wdi_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wdi_i), .q_o(wdi_s));

  wdt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_btn_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(btn_ni), .q_o(btn_s_n));

  wdt_timer #(.CNT_W(CNT_W), .DEF_T(DEF_T), .UNIT_T(UNIT_T), .GAP_T(GAP_T)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .pwr_good_i(pwr_good_i),
    .dis_i(wd_dis_i), .in_rst_i(in_rst), .wdi_s_i(wdi_s), .sel_i(wd_sel_i),
    .wdo_o(wdo_o), .timeout_o(wd_timeout));

  wdt_btn #(.CNT_W(CNT_W), .BTN_T(BTN_T)) u_btn (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .btn_s_ni(btn_s_n),
    .in_rst_i(in_rst), .start_o(btn_start));

  wdt_rst_gen #(.CNT_W(CNT_W), .RST_T(RST_T)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .pwr_good_i(pwr_good_i),
    .start_i(wd_timeout | btn_start), .in_rst_o(in_rst));

  assign rst_no = ~in_rst;

  // R7
  btn_starts_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btn_start |=> !rst_no);
  // R3
  timeout_both_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_timeout |=> (!rst_no && !wdo_o));
  // R11
  init_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $past(tick_i));
endmodule

// File: tb/wdt_reset_supervisor_tb.sv
module wdt_reset_supervisor_tb;
  localparam int DEF_T = 10, UNIT_T = 2, REPEAT_T = 16, RST_T = 5, BTN_T = 3;
  localparam int GAP_T = REPEAT_T - RST_T;

  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, pwr_good_i = 1'b1, wd_dis_i = 1'b0;
  logic [2:0] wd_sel_i = 3'd0;
  logic wdi_i = 1'b0, btn_ni = 1'b1;
  logic rst_no, wdo_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_reset_supervisor #(.CNT_W(8), .DEF_T(DEF_T), .UNIT_T(UNIT_T), .REPEAT_T(REPEAT_T),
    .RST_T(RST_T), .BTN_T(BTN_T), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .pwr_good_i(pwr_good_i),
    .wd_dis_i(wd_dis_i), .wd_sel_i(wd_sel_i), .wdi_i(wdi_i), .btn_ni(btn_ni),
    .rst_no(rst_no), .wdo_o(wdo_o));

  function automatic int tmo(input int c);
    return (c == 0) ? DEF_T : (UNIT_T << (c - 1));
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tk(input int n);
    repeat (n) begin
      tick_i = 1'b1; @(negedge clk);
      tick_i = 1'b0; @(negedge clk); @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic toggle();
    wdi_i = ~wdi_i; cyc(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_ni = 1'b1; cyc(1);
    chk("R11 rst after init", rst_no, 1'b0);
    chk("R11 wdo after init", wdo_o, 1'b1);
    tk(RST_T - 1); chk("R11 rst held", rst_no, 1'b0);
    tk(1);         chk("R11 rst released", rst_no, 1'b1);
    // R10: timer starts full after power-on reset
    tk(DEF_T - 1); chk("R10 no early timeout", rst_no, 1'b1);
    tk(1);         chk("R10 timeout rst", rst_no, 1'b0);
    chk("R3 timeout wdo", wdo_o, 1'b0);
    tk(RST_T);     chk("R3 pulse end", rst_no, 1'b1);
    chk("R4 wdo still low", wdo_o, 1'b0);
    toggle();      chk("R4 wdo high on change", wdo_o, 1'b1);

    for (int c = 0; c < 8; c++) begin
      wd_sel_i = 3'(c);
      toggle();
      tk(tmo(c) - 1); chk("R2 before timeout", rst_no, 1'b1);
      chk("R1 wdo high", wdo_o, 1'b1);
      tk(1);          chk("R2 at timeout", rst_no, 1'b0);
      chk("R3 wdo low", wdo_o, 1'b0);
      tk(RST_T - 1);  chk("R3 held", rst_no, 1'b0);
      tk(1);          chk("R3 released", rst_no, 1'b1);
      chk("R4 stays low", wdo_o, 1'b0);
      tk(GAP_T - 1);  chk("R5 before repeat", rst_no, 1'b1);
      tk(1);          chk("R5 repeat pulse", rst_no, 1'b0);
      chk("R5 wdo low", wdo_o, 1'b0);
      toggle();       chk("R4 change during pulse", wdo_o, 1'b1);
      chk("R4 pulse continues", rst_no, 1'b0);
      tk(RST_T);      chk("R3 repeat end", rst_no, 1'b1);
    end
    wd_sel_i = 3'd0;

    // R1: short pulse restarts
    toggle(); tk(6);
    wdi_i = ~wdi_i; cyc(1); wdi_i = ~wdi_i; cyc(4);
    tk(DEF_T - 1); chk("R1 pulse restart", rst_no, 1'b1);
    tk(1);         chk("R1 timeout after pulse", rst_no, 1'b0);
    tk(RST_T); toggle();

    // R9: disable
    wd_dis_i = 1'b1; cyc(1);
    tk(DEF_T + 5); chk("R9 no timeout disabled", rst_no, 1'b1);
    chk("R9 wdo high disabled", wdo_o, 1'b1);
    wd_dis_i = 1'b0;
    tk(DEF_T - 1); chk("R9 restart after enable", rst_no, 1'b1);
    tk(1);         chk("R9 timeout after enable", rst_no, 1'b0);
    tk(RST_T);     chk("R9 wdo low before disable", wdo_o, 1'b0);
    wd_dis_i = 1'b1; cyc(2); chk("R9 disable forces wdo", wdo_o, 1'b1);
    wd_dis_i = 1'b0; cyc(2); toggle();

    // R6: power loss
    pwr_good_i = 1'b0; cyc(2);
    chk("R6 rst on power loss", rst_no, 1'b0);
    chk("R9 wdo on power loss", wdo_o, 1'b1);
    tk(DEF_T + 3); chk("R6 rst held while bad", rst_no, 1'b0);
    chk("R9 wdo held while bad", wdo_o, 1'b1);
    pwr_good_i = 1'b1; cyc(2);
    tk(RST_T - 1); chk("R6 held after return", rst_no, 1'b0);
    tk(1);         chk("R6 released", rst_no, 1'b1);
    tk(DEF_T - 1); chk("R10 full timeout after power", rst_no, 1'b1);
    tk(1);         chk("R10 timeout after power", rst_no, 1'b0);
    tk(RST_T); toggle();

    // R7: button
    btn_ni = 1'b0; cyc(3); tk(BTN_T - 1); btn_ni = 1'b1; cyc(4);
    chk("R7 short hold ignored", rst_no, 1'b1);
    btn_ni = 1'b0; cyc(3); tk(BTN_T);
    chk("R7 no reset while held", rst_no, 1'b1);
    btn_ni = 1'b1; cyc(4);
    chk("R7 reset on release", rst_no, 1'b0);
    tk(RST_T - 1); chk("R7 held", rst_no, 1'b0);
    tk(1);         chk("R7 released", rst_no, 1'b1);
    tk(DEF_T - 1); chk("R10 full timeout after button", rst_no, 1'b1);
    tk(1);         chk("R10 timeout after button", rst_no, 1'b0);
    tk(RST_T); toggle();

    // R8: button during active reset
    pwr_good_i = 1'b0; cyc(2); pwr_good_i = 1'b1;
    btn_ni = 1'b0; cyc(3); tk(RST_T - 1);
    chk("R8 reset still active", rst_no, 1'b0);
    btn_ni = 1'b1; cyc(4);
    tk(1); chk("R8 reset ends on time", rst_no, 1'b1);
    cyc(4); chk("R8 no new pulse", rst_no, 1'b1);
    tk(2);  chk("R8 still released", rst_no, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule